// File: doc/BRIEF.md
# Handshaking SPI Command Host

This block is the host side of a serial link to a slave that needs processing time before it can answer. Given a start request, it sends a command of one or two bytes in SPI mode 0. Each command byte goes in its own select frame, and two command bytes are separated by a programmable quiet gap. The host then fetches the requested number of response bytes, one at a time, and hands each byte to the local logic as a one-cycle stream beat. A `done` pulse ends the transaction.

The slave signals readiness on an active-low data-ready line. For every response byte the host goes through the same steps:

1. Wait for data-ready to go low.
2. Lower select.
3. Shift out a zero byte while the slave's answer is shifted in.
4. Keep select low until data-ready returns high.
5. Release select.

Response bytes are therefore never streamed back to back. If data-ready does not fall within a programmable window, the transaction ends with a timeout flag. The SCK half period, the inter-byte gap and the timeout are parameters given in system clock cycles. The default SCK divider keeps SCK below 3 MHz with a 50 MHz system clock.

Top module: `spi_cmd_host`

## Requirements
- R1: `sck` is low while idle and whenever `ss_n` changes level; `sck` is high only while `ss_n` is low.
- R2: Bytes go out MSB first on `mosi`, which changes only while `sck` is low; `miso` is captured on each rising `sck` edge, MSB first.
- R3: With `cmd_len`=0 one command byte (`cmd_byte0`) is sent; with `cmd_len`=1, `cmd_byte0` then `cmd_byte1` are sent, each in its own select frame, with `ss_n` high for exactly GAP_CYCLES clock cycles between the frames.
- R4: After the command, and after each response byte, `ss_n` stays high until the two-flop-synchronized `drdy_n` is seen low.
- R5: Each response fetch transmits the byte 0x00.
- R6: After a fetch frame, `ss_n` stays low until synchronized `drdy_n` is high. `ss_n` then rises, and in the same cycle `resp_valid` pulses with the received byte on `resp_data`.
- R7: Exactly `resp_count` response bytes are fetched, and `done` pulses for one cycle after the last one. With `resp_count`=0, `done` pulses in the cycle the command frame is released, without any wait on `drdy_n`.
- R8: If `drdy_n` is not seen low within TIMEOUT_CYCLES clock cycles of entering a wait, `done` pulses with `timeout_err`=1, `ss_n` stays high, and no further bytes are fetched.
- R9: `start` is ignored while `busy` is 1; `busy` falls only together with a `done` pulse.
- R10: Each `sck` high phase and low phase within a frame lasts CLK_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (sampled when idle) |
| cmd_len | input | 1 | 0: one command byte, 1: two |
| cmd_byte0 | input | 8 | First command byte |
| cmd_byte1 | input | 8 | Second command byte |
| resp_count | input | CNT_W | Number of response bytes to fetch |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| timeout_err | output | 1 | Set with `done` when data-ready timed out |
| resp_data | output | 8 | Response byte, valid with `resp_valid` |
| resp_valid | output | 1 | One-cycle pulse per response byte |
| sck | output | 1 | SPI clock, idles low |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Host to slave data |
| miso | input | 1 | Slave to host data |
| drdy_n | input | 1 | Active-low data-ready from the slave |

## Verification
The bench builds the block with CLK_DIV=2, GAP_CYCLES=20, TIMEOUT_CYCLES=200 and CNT_W=4. The tiny gap and timeout make exact gap lengths and both kinds of timeout cheap to exercise: a timeout before the first response byte and one between response bytes. The short divider still leaves distinct high and low SCK phases to measure. The 4-bit count allows multi-byte responses without long runs.

// File: rtl/spi_cmd_host.sv
module spi_cmd_host #(
  parameter int CLK_DIV        = 9,
  parameter int GAP_CYCLES     = 2500,
  parameter int TIMEOUT_CYCLES = 500000,
  parameter int CNT_W          = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmd_len,
  input  logic [7:0]       cmd_byte0,
  input  logic [7:0]       cmd_byte1,
  input  logic [CNT_W-1:0] resp_count,
  output logic             busy,
  output logic             done,
  output logic             timeout_err,
  output logic [7:0]       resp_data,
  output logic             resp_valid,
  output logic             sck,
  output logic             ss_n,
  output logic             mosi,
  input  logic             miso,
  input  logic             drdy_n
);
  localparam int TMAX = (GAP_CYCLES > TIMEOUT_CYCLES) ? GAP_CYCLES : TIMEOUT_CYCLES;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int DW   = $clog2(CLK_DIV + 1);

  typedef enum logic [2:0] {S_IDLE, S_FRAME, S_HOLD, S_GAP, S_WLO, S_WHI} st_t;

  st_t             st;
  logic [DW-1:0]   div_cnt;
  logic [TW-1:0]   tcnt;
  logic            ph, second, fetching;
  logic [2:0]      bitn;
  logic [7:0]      shreg, rxsr, byte1;
  logic [CNT_W-1:0] left;
  logic            drdy_m, drdy_s;

  wire half_done = (div_cnt == DW'(CLK_DIV - 1));

  assign busy      = (st != S_IDLE);
  assign mosi      = shreg[7];
  assign resp_data = rxsr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      div_cnt <= '0;
      tcnt <= '0;
      ph <= 1'b0;
      second <= 1'b0;
      fetching <= 1'b0;
      bitn <= '0;
      shreg <= '0;
      rxsr <= '0;
      byte1 <= '0;
      left <= '0;
      drdy_m <= 1'b1;
      drdy_s <= 1'b1;
      sck <= 1'b0;
      ss_n <= 1'b1;
      resp_valid <= 1'b0;
      done <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      resp_valid  <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      drdy_m      <= drdy_n;
      drdy_s      <= drdy_m;
      case (st)
        S_IDLE: if (start) begin
          shreg    <= cmd_byte0;
          byte1    <= cmd_byte1;
          second   <= cmd_len;
          left     <= resp_count;
          fetching <= 1'b0;
          ss_n     <= 1'b0;
          div_cnt  <= '0;
          ph       <= 1'b0;
          bitn     <= '0;
          st       <= S_FRAME;
        end
        S_FRAME: begin
          if (half_done) begin
            div_cnt <= '0;
            if (!ph) begin
              sck  <= 1'b1;
              ph   <= 1'b1;
              rxsr <= {rxsr[6:0], miso};
            end else begin
              sck <= 1'b0;
              ph  <= 1'b0;
              if (bitn == 3'd7) st <= S_HOLD;
              else begin
                bitn  <= bitn + 3'd1;
                shreg <= {shreg[6:0], 1'b0};
              end
            end
          end else div_cnt <= div_cnt + DW'(1);
        end
        S_HOLD: begin
          if (half_done) begin
            div_cnt <= '0;
            if (fetching) st <= S_WHI;
            else begin
              ss_n <= 1'b1;
              tcnt <= '0;
              if (second) begin
                second <= 1'b0;
                shreg  <= byte1;
                st     <= S_GAP;
              end else begin
                shreg <= '0;
                if (left == '0) begin
                  done <= 1'b1;
                  st   <= S_IDLE;
                end else st <= S_WLO;
              end
            end
          end else div_cnt <= div_cnt + DW'(1);
        end
        S_GAP: begin
          if (tcnt == TW'(GAP_CYCLES - 1)) begin
            ss_n    <= 1'b0;
            div_cnt <= '0;
            ph      <= 1'b0;
            bitn    <= '0;
            st      <= S_FRAME;
          end else tcnt <= tcnt + TW'(1);
        end
        S_WLO: begin
          if (!drdy_s) begin
            ss_n     <= 1'b0;
            fetching <= 1'b1;
            shreg    <= '0;
            div_cnt  <= '0;
            ph       <= 1'b0;
            bitn     <= '0;
            st       <= S_FRAME;
          end else if (tcnt == TW'(TIMEOUT_CYCLES - 1)) begin
            done        <= 1'b1;
            timeout_err <= 1'b1;
            st          <= S_IDLE;
          end else tcnt <= tcnt + TW'(1);
        end
        S_WHI: if (drdy_s) begin
          ss_n       <= 1'b1;
          resp_valid <= 1'b1;
          left       <= left - CNT_W'(1);
          tcnt       <= '0;
          if (left == CNT_W'(1)) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else st <= S_WLO;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_host_chk.sv
module spi_cmd_host_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic ss_n,
  input logic mosi,
  input logic resp_valid,
  input logic done,
  input logic timeout_err,
  input logic busy
);
  a_r1_sck_only_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !ss_n);
  a_r1_select_edge_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ss_n) || $fell(ss_n)) |-> !sck);
  a_r2_mosi_steady_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));
  a_r2_mosi_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  a_r6_valid_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (ss_n && !$past(ss_n)));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (done && ss_n));
  a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind spi_cmd_host spi_cmd_host_chk u_chk (.*);

// File: tb/test_spi_cmd_host.sv
module test_spi_cmd_host;
  localparam int CLK_DIV = 2, GAP = 20, TMO = 200, CW = 4;

  logic clk = 0, rst_n = 0, start = 0, cmd_len = 0, miso = 0, drdy_n = 1;
  logic [7:0] cmd_byte0 = 0, cmd_byte1 = 0, resp_data;
  logic [CW-1:0] resp_count = 0;
  logic busy, done, timeout_err, resp_valid, sck, ss_n, mosi;

  int checks = 0, failures = 0, cyc = 0, falls = 0, t_fall = 0, t_rel = 0;
  logic [7:0] exp_resp[$];
  logic [7:0] rsp[0:7];

  always #10 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;
  always @(negedge ss_n) falls++;

  spi_cmd_host #(.CLK_DIV(CLK_DIV), .GAP_CYCLES(GAP), .TIMEOUT_CYCLES(TMO), .CNT_W(CW)) i_spi_cmd_host (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len), .cmd_byte0(cmd_byte0),
    .cmd_byte1(cmd_byte1), .resp_count(resp_count), .busy(busy), .done(done),
    .timeout_err(timeout_err), .resp_data(resp_data), .resp_valid(resp_valid),
    .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso), .drdy_n(drdy_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && resp_valid) begin
    if (exp_resp.size() == 0) chk(0, "R7 unexpected resp_valid", resp_data, 0);
    else begin
      logic [7:0] e;
      e = exp_resp.pop_front();
      chk(resp_data == e, "R6 resp_data", resp_data, e);
    end
  end

  task automatic frame(input logic [7:0] tx, output logic [7:0] rx);
    int t;
    bit bad;
    rx = 0;
    bad = 0;
    @(negedge ss_n);
    t_fall = cyc;
    chk(sck == 0, "R1 sck low at select", sck, 0);
    miso = tx[7];
    for (int i = 0; i < 8; i++) begin
      @(posedge sck);
      t = cyc;
      rx = {rx[6:0], mosi};
      @(negedge sck);
      if (cyc - t != CLK_DIV) bad = 1;
      if (i < 7) miso = tx[6-i];
    end
    chk(!bad, "R10 sck half period", bad, 0);
  endtask

  task automatic run(input logic two, input logic [7:0] b0, input logic [7:0] b1,
                     input int n, input int provide, input bit poke);
    logic [7:0] rx;
    int f0, w;
    f0 = falls;
    for (int k = 0; k < provide; k++) exp_resp.push_back(rsp[k]);
    fork
      frame(8'h00, rx);
      begin
        @(negedge clk);
        start = 1; cmd_len = two; cmd_byte0 = b0; cmd_byte1 = b1; resp_count = CW'(n);
        @(negedge clk);
        start = 0; cmd_byte0 = ~b0;
        if (poke) begin
          @(negedge clk); start = 1; cmd_len = 0; cmd_byte0 = 8'hFF; resp_count = 0;
          @(negedge clk); start = 0;
        end
      end
    join
    chk(rx == b0, "R3 first command byte (R2 MSB first)", rx, b0);
    @(posedge ss_n); t_rel = cyc;
    if (two) begin
      frame(8'h00, rx);
      chk(t_fall - t_rel == GAP, "R3 gap between command frames", t_fall - t_rel, GAP);
      chk(rx == b1, "R3 second command byte", rx, b1);
      @(posedge ss_n); t_rel = cyc;
    end
    for (int k = 0; k < n && k < provide; k++) begin
      repeat (6) @(negedge clk);
      chk(ss_n == 1, "R4 select waits for data-ready", ss_n, 1);
      fork
        frame(rsp[k], rx);
        begin @(negedge clk); drdy_n = 0; end
      join
      chk(rx == 8'h00, "R5 fetch sends zero", rx, 0);
      repeat (12) @(negedge clk);
      chk(ss_n == 0, "R6 select held until data-ready high", ss_n, 0);
      drdy_n = 1;
      @(posedge ss_n); t_rel = cyc;
    end
    @(negedge clk);
    w = 0;
    while (!done && w < TMO + 50) begin @(negedge clk); w++; end
    chk(done == 1, "R7 done pulse", done, 1);
    chk(timeout_err == (provide < n), "R8 timeout flag", timeout_err, provide < n);
    if (provide < n)
      chk(cyc - t_rel >= TMO - 1 && cyc - t_rel <= TMO + 2, "R8 timeout window", cyc - t_rel, TMO);
    if (n == 0) chk(w == 0, "R7 zero-count done at release", w, 0);
    repeat (40) @(negedge clk);
    chk(busy == 0 && ss_n == 1, "R9 idle after done", {busy, ss_n}, 1);
    chk(falls - f0 == (two ? 2 : 1) + ((provide < n) ? provide : n), "R9 frame count",
        falls - f0, (two ? 2 : 1) + ((provide < n) ? provide : n));
    chk(exp_resp.size() == 0, "R7 all responses delivered", exp_resp.size(), 0);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > 100000) begin
        chk(0, "watchdog", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ss_n == 1 && sck == 0 && busy == 0 && done == 0 && resp_valid == 0,
        "R1 reset state", {ss_n, sck, busy, done, resp_valid}, 5'b10000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    run(0, 8'hA5, 8'h00, 0, 0, 0);
    rsp[0] = 8'h81;
    run(1, 8'h3C, 8'hC3, 1, 1, 0);
    rsp[0] = 8'h01; rsp[1] = 8'h80; rsp[2] = 8'hFE;
    run(0, 8'h5A, 8'h00, 3, 3, 1);
    run(1, 8'h12, 8'h34, 2, 0, 0);
    rsp[0] = 8'h6D;
    run(0, 8'h99, 8'h00, 2, 1, 0);
    rsp[0] = 8'hB7;
    run(1, 8'hF0, 8'h0F, 1, 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule